// File: doc/BRIEF.md
# Early Branch Resolution Unit

This unit sits in the decode stage of a five-stage pipeline with 32-bit fixed-width instructions. For the instruction now in decode it tests one register against zero. It also forms the branch or jump target with its own adder. It then tells fetch where to go next and whether the instruction fetched behind the branch must be killed. Because the decision is made in decode rather than in the memory stage, a control transfer costs at most one cycle.

A mode input picks one of three control-hazard policies:
- **Hold:** every branch or jump refetches from its resolved address and kills the slot behind it.
- **Predict not taken:** sequential fetch goes on, and the slot is killed only when the branch is taken.
- **Single delay slot:** the slot behind the branch always executes, and the change of flow follows it.

A conditional branch may read a register that the instruction just ahead has not yet written. For that case the unit asks the pipeline to hold decode for one cycle after an ALU producer and for two cycles after a load. The branch resolves only once the hold is over.

Top module: `early_branch_unit`

## Requirements
- R1: The branch kind is encoded as 00 none, 01 branch-if-zero (taken when the register is 0), 10 branch-if-nonzero (taken when the register is not 0) and 11 jump (always taken). When kind 00 is in decode, or the valid input is low, `redirect_o`, `flush_o` and `stall_o` stay low, whatever the dependency inputs are.
- R2: A conditional branch targets `pc4_i + (imm_i << 2)`, modulo 2^32.
- R3: A jump targets `{pc4_i[31:28], jidx_i, 2'b00}`.
- R4: In hold mode (mode 00, and also 11), every resolving branch or jump raises `redirect_o` and `flush_o`. `npc_o` is then the target if the branch is taken and `pc4_i` if it is not.
- R5: In predict-not-taken mode (mode 01), a taken branch or jump raises `redirect_o` and `flush_o` with `npc_o` equal to the target. A branch that is not taken raises neither.
- R6: In delay-slot mode (mode 10), `flush_o` never rises. A taken branch or jump raises `redirect_o` with `npc_o` equal to the target.
- R7: Whenever `redirect_o` is low, `npc_o` equals `seq_pc_i`.
- R8: A conditional branch that enters decode with `dep_alu_i` high, and `dep_load_i` low, holds `stall_o` high for exactly one cycle and resolves in the next cycle.
- R9: A conditional branch that enters decode with `dep_load_i` high holds `stall_o` high for exactly two cycles, whatever `dep_alu_i` is, and then resolves.
- R10: While `stall_o` is high, `redirect_o` and `flush_o` are low. The redirect and flush of a branch appear only in the first cycle after its stall ends.
- R11: A jump ignores the dependency inputs. It never stalls and resolves in its first decode cycle.
- R12: After reset `stall_o` is low, and a branch with no dependency resolves in its first decode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| br_kind_i | input | 2 | Branch kind: 00 none, 01 if-zero, 10 if-nonzero, 11 jump |
| mode_i | input | 2 | Policy: 00/11 hold, 01 predict not taken, 10 delay slot |
| rs_val_i | input | 32 | Register operand under test |
| imm_i | input | 32 | Sign-extended branch offset, in words |
| jidx_i | input | 26 | Jump word index |
| pc4_i | input | 32 | Address of the branch plus 4 |
| seq_pc_i | input | 32 | Sequential next address from fetch |
| dep_alu_i | input | 1 | Instruction just ahead is an ALU op writing the tested register |
| dep_load_i | input | 1 | Instruction just ahead is a load writing the tested register |
| npc_o | output | 32 | Next fetch address |
| redirect_o | output | 1 | Fetch takes `npc_o` instead of its sequential address |
| flush_o | output | 1 | Kill the instruction fetched behind the branch |
| stall_o | output | 1 | Hold fetch and decode, and send a bubble forward |

## Verification
Two things can coincide: a dependency hold and the resolution of the same branch. A taken branch that carries `dep_alu_i` or `dep_load_i` asks for both a stall and a redirect in the same decode cycle. The bench provokes this with directed and random branches that carry dependencies, in all three modes. It judges the outcome cycle by cycle: no redirect or flush may appear while the stall is high, and the expected redirect, flush and address must appear in exactly the first cycle after the stall.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_BEQZ = 2'b01,
    BK_BNEZ = 2'b10,
    BK_JUMP = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    PM_HOLD  = 2'b00,
    PM_PNT   = 2'b01,
    PM_DELAY = 2'b10,
    PM_HOLDX = 2'b11
  } pol_mode_e;
endpackage

// File: rtl/ebu_cond.sv
module ebu_cond
  import ebu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val_i,
  input  br_kind_e        kind_i,
  output logic            taken_o,
  output logic            is_cond_o,
  output logic            is_ctl_o
);
  logic is_zero;

  assign is_zero = (rs_val_i == '0);

  always_comb begin
    taken_o   = 1'b0;
    is_cond_o = 1'b0;
    is_ctl_o  = 1'b1;
    unique case (kind_i)
      BK_BEQZ: begin taken_o = is_zero;  is_cond_o = 1'b1; end
      BK_BNEZ: begin taken_o = !is_zero; is_cond_o = 1'b1; end
      BK_JUMP: taken_o = 1'b1;
      default: is_ctl_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ebu_target.sv
module ebu_target #(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc4_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic              is_jump_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int JSPAN = JIDX_W + 2;

  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;

  // dedicated decode-stage adder
  assign br_tgt  = pc4_i + (imm_i << 2);
  assign jmp_tgt = {pc4_i[XLEN-1:JSPAN], jidx_i, 2'b00};
  assign target_o = is_jump_i ? jmp_tgt : br_tgt;
endmodule

// File: rtl/ebu_hazard.sv
module ebu_hazard #(
  parameter int ALU_STALLS  = 1,
  parameter int LOAD_STALLS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_valid_i,
  input  logic dep_alu_i,
  input  logic dep_load_i,
  output logic stall_o
);
  localparam int MAXS  = (LOAD_STALLS > ALU_STALLS) ? LOAD_STALLS : ALU_STALLS;
  localparam int CNT_W = $clog2(MAXS + 1);

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_q;
  logic             served_q;

  always_comb begin
    need = '0;
    if (cond_valid_i) begin
      if (dep_load_i)     need = CNT_W'(LOAD_STALLS);
      else if (dep_alu_i) need = CNT_W'(ALU_STALLS);
    end
  end

  // dependency inputs only matter on a branch's first decode cycle
  assign stall_o = (cnt_q != '0) || (!served_q && need != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      served_q <= 1'b0;
    end else if (stall_o) begin
      served_q <= 1'b1;
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      else             cnt_q <= need - CNT_W'(1);
    end else begin
      served_q <= 1'b0;
      cnt_q    <= '0;
    end
  end
endmodule

// File: rtl/early_branch_unit.sv
module early_branch_unit
  import ebu_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int JIDX_W      = 26,
  parameter int ALU_STALLS  = 1,
  parameter int LOAD_STALLS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_valid_i,
  input  logic [1:0]        br_kind_i,
  input  logic [1:0]        mode_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [XLEN-1:0]   pc4_i,
  input  logic [XLEN-1:0]   seq_pc_i,
  input  logic              dep_alu_i,
  input  logic              dep_load_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              redirect_o,
  output logic              flush_o,
  output logic              stall_o
);
  br_kind_e        kind;
  pol_mode_e       mode;
  logic            taken, is_cond, is_ctl;
  logic [XLEN-1:0] target;
  logic            resolve;
  logic [XLEN-1:0] resolved_pc;

  assign kind = br_kind_e'(br_kind_i);
  assign mode = pol_mode_e'(mode_i);

  ebu_cond #(.XLEN(XLEN)) u_cond (
    .rs_val_i (rs_val_i),
    .kind_i   (kind),
    .taken_o  (taken),
    .is_cond_o(is_cond),
    .is_ctl_o (is_ctl)
  );

  ebu_target #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_target (
    .pc4_i    (pc4_i),
    .imm_i    (imm_i),
    .jidx_i   (jidx_i),
    .is_jump_i(kind == BK_JUMP),
    .target_o (target)
  );

  ebu_hazard #(.ALU_STALLS(ALU_STALLS), .LOAD_STALLS(LOAD_STALLS)) u_hazard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cond_valid_i(id_valid_i && is_cond),
    .dep_alu_i   (dep_alu_i),
    .dep_load_i  (dep_load_i),
    .stall_o     (stall_o)
  );

  // redirect waits until the dependency stall is over
  assign resolve     = id_valid_i && is_ctl && !stall_o;
  assign resolved_pc = taken ? target : pc4_i;

  always_comb begin
    redirect_o = 1'b0;
    flush_o    = 1'b0;
    unique case (mode)
      PM_PNT: begin
        redirect_o = resolve && taken;
        flush_o    = resolve && taken;
      end
      PM_DELAY: redirect_o = resolve && taken;
      default: begin
        redirect_o = resolve;
        flush_o    = resolve;
      end
    endcase
  end

  assign npc_o = redirect_o ? resolved_pc : seq_pc_i;
endmodule

// File: rtl/early_branch_unit_chk.sv
module early_branch_unit_chk #(
  parameter int XLEN        = 32,
  parameter int LOAD_STALLS = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            id_valid_i,
  input logic [1:0]      br_kind_i,
  input logic [1:0]      mode_i,
  input logic            dep_load_i,
  input logic [XLEN-1:0] npc_o,
  input logic [XLEN-1:0] seq_pc_i,
  input logic            redirect_o,
  input logic            flush_o,
  input logic            stall_o
);
  localparam int RW = $clog2(LOAD_STALLS + 2);

  logic [RW-1:0] run_q;
  logic          prev_stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= '0;
      prev_stall_q <= 1'b0;
    end else begin
      prev_stall_q <= stall_o;
      run_q        <= stall_o ? run_q + RW'(1) : '0;
    end
  end

  a_r10_no_redirect_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!redirect_o && !flush_o));

  a_r6_delay_never_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> !flush_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_valid_i || br_kind_i == 2'b00) |-> (!redirect_o && !flush_o && !stall_o));

  a_r11_jump_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && br_kind_i == 2'b11) |-> !stall_o);

  a_r9_load_stall_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !prev_stall_q && dep_load_i && id_valid_i &&
     (br_kind_i == 2'b01 || br_kind_i == 2'b10)) |=> stall_o);

  a_r9_stall_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= RW'(LOAD_STALLS)) |-> !stall_o);

  a_r7_seq_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> (npc_o == seq_pc_i));
endmodule

bind early_branch_unit early_branch_unit_chk #(.XLEN(XLEN), .LOAD_STALLS(LOAD_STALLS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .id_valid_i(id_valid_i),
  .br_kind_i (br_kind_i),
  .mode_i    (mode_i),
  .dep_load_i(dep_load_i),
  .npc_o     (npc_o),
  .seq_pc_i  (seq_pc_i),
  .redirect_o(redirect_o),
  .flush_o   (flush_o),
  .stall_o   (stall_o)
);

// File: tb/tb_early_branch_unit.sv
`timescale 1ns/1ps
module tb_early_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid;
  logic [1:0]  kind, mode;
  logic [31:0] rs_val, imm, pc4, seq_pc;
  logic [25:0] jidx;
  logic        dep_alu, dep_load;
  logic [31:0] npc;
  logic        redirect, flush, stall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  early_branch_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid), .br_kind_i(kind),
    .mode_i(mode), .rs_val_i(rs_val), .imm_i(imm), .jidx_i(jidx), .pc4_i(pc4),
    .seq_pc_i(seq_pc), .dep_alu_i(dep_alu), .dep_load_i(dep_load),
    .npc_o(npc), .redirect_o(redirect), .flush_o(flush), .stall_o(stall)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_target(input logic [1:0] k, input logic [31:0] p4,
                                             input logic [31:0] im, input logic [25:0] ji);
    if (k == 2'b11) return {p4[31:28], ji, 2'b00};
    return p4 + {im[29:0], 2'b00};
  endfunction

  function automatic bit exp_taken(input logic [1:0] k, input logic [31:0] r);
    case (k)
      2'b01:   return r == 0;
      2'b10:   return r != 0;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // present one decode instruction and check every cycle until it leaves decode
  task automatic run_instr(input bit v, input logic [1:0] k, input logic [1:0] m,
                           input logic [31:0] r, input logic [31:0] im, input logic [25:0] ji,
                           input logic [31:0] p4, input logic [31:0] sq,
                           input bit da, input bit dl);
    int  need;
    bit  ctl, tk, e_red, e_fl;
    logic [31:0] e_npc;
    ctl  = v && (k != 2'b00);
    tk   = exp_taken(k, r);
    need = (v && (k == 2'b01 || k == 2'b10)) ? (dl ? 2 : (da ? 1 : 0)) : 0;
    @(negedge clk);
    id_valid = v; kind = k; mode = m; rs_val = r; imm = im; jidx = ji;
    pc4 = p4; seq_pc = sq; dep_alu = da; dep_load = dl;
    for (int c = 0; c < need; c++) begin
      #1;
      chk(dl ? "R9 stall" : "R8 stall", {31'b0, stall}, 32'd1);
      chk("R10 quiet in stall", {30'b0, redirect, flush}, 32'd0);
      @(negedge clk);
    end
    #1;
    if (!ctl) chk("R1 no stall", {31'b0, stall}, 32'd0);
    else if (k == 2'b11) chk("R11 jump no stall", {31'b0, stall}, 32'd0);
    else chk("R12 resolves", {31'b0, stall}, 32'd0);
    e_red = 0; e_fl = 0;
    if (ctl) begin
      case (m)
        2'b01:   begin e_red = tk; e_fl = tk; end
        2'b10:   begin e_red = tk; e_fl = 0;  end
        default: begin e_red = 1;  e_fl = 1;  end
      endcase
    end
    e_npc = !e_red ? sq : (tk ? exp_target(k, p4, im, ji) : p4);
    if (!ctl) chk("R1 flags", {30'b0, redirect, flush}, 32'd0);
    else if (m == 2'b01) chk("R5 flags", {30'b0, redirect, flush}, {30'b0, e_red, e_fl});
    else if (m == 2'b10) chk("R6 flags", {30'b0, redirect, flush}, {30'b0, e_red, e_fl});
    else chk("R4 flags", {30'b0, redirect, flush}, {30'b0, e_red, e_fl});
    if (!e_red) chk("R7 npc", npc, e_npc);
    else if (k == 2'b11) chk("R3 npc", npc, e_npc);
    else chk("R2 npc", npc, e_npc);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    id_valid = 0; kind = 0; mode = 0; rs_val = 0; imm = 0; jidx = 0;
    pc4 = 0; seq_pc = 32'h100; dep_alu = 0; dep_load = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 reset stall", {31'b0, stall}, 32'd0);
    chk("R12 reset flags", {30'b0, redirect, flush}, 32'd0);
    rst_n = 1'b1;

    // directed corners
    run_instr(1, 2'b01, 2'b00, 0, 32'd4, 0, 32'h1000, 32'h2000, 0, 0);
    run_instr(1, 2'b01, 2'b00, 5, 32'd4, 0, 32'h1000, 32'h2000, 0, 0);
    run_instr(1, 2'b10, 2'b01, 7, 32'hFFFF_FFFC, 0, 32'h1010, 32'h2004, 0, 0);
    run_instr(1, 2'b10, 2'b01, 0, 32'hFFFF_FFFC, 0, 32'h1010, 32'h2004, 0, 0);
    run_instr(1, 2'b01, 2'b10, 0, 32'd8, 0, 32'h1020, 32'h1024, 0, 0);
    run_instr(1, 2'b01, 2'b10, 1, 32'd8, 0, 32'h1020, 32'h1024, 0, 0);
    run_instr(1, 2'b11, 2'b11, 9, 0, 26'h3FF_FFFF, 32'hA000_0004, 32'h8, 1, 1);
    run_instr(1, 2'b01, 2'b01, 0, 32'd3, 0, 32'h40, 32'h44, 1, 0);
    run_instr(1, 2'b10, 2'b00, 3, 32'd3, 0, 32'h40, 32'h44, 1, 1);
    run_instr(1, 2'b00, 2'b00, 0, 32'd3, 0, 32'h40, 32'h44, 1, 1);
    run_instr(0, 2'b01, 2'b00, 0, 32'd3, 0, 32'h40, 32'h44, 0, 1);
    run_instr(1, 2'b01, 2'b01, 0, 32'h8000_0000, 0, 32'hFFFF_FFF0, 32'h0, 0, 0);
    run_instr(1, 2'b10, 2'b10, 2, 32'd1, 0, 32'h80, 32'h84, 0, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = ($urandom % 3 == 0) ? 32'd0 : $urandom;
      run_instr(($urandom % 8) != 0, 2'($urandom), 2'($urandom), r,
                {{16{1'($urandom)}}, 16'($urandom)}, 26'($urandom), $urandom & 32'hFFFF_FFFC,
                $urandom & 32'hFFFF_FFFC, ($urandom % 3) == 0, ($urandom % 4) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule